// File: doc/BRIEF.md
# Preamplifier Configuration Register Bank with Write-Only I2C Slave

This block is a write-only I2C target that stores the configuration of a video preamplifier. The bus lines are oversampled by a fast system clock: each one passes through a two-flop synchroniser and a glitch filter before bus conditions are decoded. The block responds to one fixed device address. After that address it takes a register index byte, then a data byte. It can take any number of further index and data pairs before the STOP.

Every register value is presented on its own parallel output bus to the analog control logic downstream. A synchronous reset stands in for the supply monitor and loads each register with its own power-on value. Register indices that hold no register are acknowledged and then dropped. A read request is never acknowledged.

Top module: `preamp_cfg_slave`

## Requirements
- R1: While `rst_n` is low, a clock edge loads these power-on values:
  - 0xB4 into contrast, brightness, the three drive gains and the three cut-off levels;
  - 0x9 into the 4-bit OSD level;
  - 0x04 into clamp control;
  - 0x1C into misc control;
  - 0x7 into the 4-bit bandwidth.
  `sda_pull_o` is low after reset.
- R2: The address byte 0xDC (7-bit address 0x6E with a write bit of 0) is acknowledged. `sda_pull_o` is high during the ninth SCL clock, and only while SCL is low or high within that clock.
- R3: An address byte that is not 0xDC gets no acknowledge. This includes 0xDD, the read request. Every following byte up to the next START is then ignored: it gets no acknowledge and causes no register write.
- R4: Bytes are taken MSB first. The byte after the address is the register index, and the byte after that is its data. Both are acknowledged, and the indexed register takes the data.
- R5: Index and data pairs may repeat within one transaction without a new START. Each data byte is applied to the index that precedes it.
- R6: Index mapping:
  - 0x01 contrast, 0x02 brightness, 0x03–0x05 drive of channels 0–2;
  - 0x07 OSD level (4 bits);
  - 0x08 clamp control, 0x09 misc control;
  - 0x0A–0x0C cut-off of channels 0–2;
  - 0x0D bandwidth (4 bits).
  The 4-bit registers keep bits 3:0 of the data byte and drop bits 7:4.
- R7: A data byte sent to index 0x00, 0x06, 0x0E–0xFF is acknowledged and changes no output.
- R8: A STOP or a repeated START before the eighth bit of a data byte aborts that byte, and no register changes. A START restarts address decoding.
- R9: A pulse on SCL shorter than the filter length (3 system clocks by default) is not seen as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus (including this block's own pull) |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| contrast_o | output | 8 | Contrast setting (index 0x01) |
| brightness_o | output | 8 | Brightness setting (index 0x02) |
| drive0_o | output | 8 | Channel 0 drive gain (index 0x03) |
| drive1_o | output | 8 | Channel 1 drive gain (index 0x04) |
| drive2_o | output | 8 | Channel 2 drive gain (index 0x05) |
| osd_level_o | output | 4 | OSD overlay level (index 0x07) |
| clamp_cfg_o | output | 8 | Clamp pulse control (index 0x08) |
| misc_cfg_o | output | 8 | Miscellaneous control (index 0x09) |
| cutoff0_o | output | 8 | Channel 0 cut-off level (index 0x0A) |
| cutoff1_o | output | 8 | Channel 1 cut-off level (index 0x0B) |
| cutoff2_o | output | 8 | Channel 2 cut-off level (index 0x0C) |
| bandwidth_o | output | 4 | Bandwidth setting (index 0x0D) |

## Verification
An SCL edge reaches the decoder 2 synchroniser clocks plus 3 filter clocks plus 1 edge-detect clock after it appears on the pins. The acknowledge pull therefore starts about six system clocks after the falling SCL edge that ends the eighth bit. A register write lands one clock after that. The bench drives SCL with a 40-clock half period. It samples the acknowledge pull in the middle of the ninth clock's high phase, and it reads the register outputs 20 clocks after each STOP. Both sample points lie well clear of these latencies. The sweeps cover every index 0x00–0x0F plus two out-of-range indices, both as pairs packed into one transaction and as single writes. The expected contents come from a bench-side model of the power-on values and field masks.

// File: rtl/pcfg_pkg.sv
// Package for the preamplifier configuration bank.
// Holds the register count, the device address, the power-on value and
// the writable-bit mask of each index, and the byte-phase type.
// Assumes indices above REG_CNT-1 hold no register.
package pcfg_pkg;

    localparam int          REG_CNT  = 16;
    localparam int          DATA_W   = 8;
    localparam logic [6:0]  DEV_ADDR = 7'h6E;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_SUB  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    // Power-on value of each index.
    function automatic logic [DATA_W-1:0] por_value(input int idx);
        case (idx)
            7:       por_value = 8'h09;
            8:       por_value = 8'h04;
            9:       por_value = 8'h1C;
            13:      por_value = 8'h07;
            1, 2, 3, 4, 5, 10, 11, 12:
                     por_value = 8'hB4;
            default: por_value = 8'h00;
        endcase
    endfunction

    // Writable bits of each index; zero means no register.
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        case (idx)
            7, 13:   field_mask = 8'h0F;
            1, 2, 3, 4, 5, 8, 9, 10, 11, 12:
                     field_mask = 8'hFF;
            default: field_mask = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pcfg_deglitch.sv
// Two-flop synchroniser followed by a stability filter for one bus line.
// The output follows the input only after it has held a new level for
// STABLE_CYC system clocks. Resets to 1 (idle bus level).
module pcfg_deglitch #(
    parameter int STABLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw};
    end

    // Accept a new level once it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clean <= 1'b1;
        end else if (sync_q[1] == clean) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
            cnt_q <= '0;
            clean <= sync_q[1];
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pcfg_wr_fsm.sv
// Write-only I2C protocol engine working on filtered SCL/SDA.
// Decodes START/STOP, shifts bytes MSB first, acknowledges the device
// address (write only), then alternates index and data bytes. It issues
// a one-cycle write strobe when a data byte completes. Assumes SCL is
// much slower than clk.
module pcfg_wr_fsm
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    output logic              ack_drv,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              idle
);
    logic              scl_q, sda_q, busy_q;
    logic [3:0]        bit_cnt;
    logic [DATA_W-1:0] shreg, sub_q;
    phase_t            phase;

    logic scl_rise, scl_fall, start_c, stop_c;

    // Bus condition decode from the previous and current line levels.
    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        start_c  = scl & scl_q & sda_q & ~sda;
        stop_c   = scl & scl_q & ~sda_q & sda;
    end

    // Byte reception, acknowledge control and write strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            busy_q  <= 1'b0;
            ack_drv <= 1'b0;
            wr_en   <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            sub_q   <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            phase   <= PH_ADDR;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            wr_en <= 1'b0;
            if (start_c) begin
                busy_q  <= 1'b1;
                ack_drv <= 1'b0;
                bit_cnt <= '0;
                phase   <= PH_ADDR;
            end else if (stop_c) begin
                busy_q  <= 1'b0;
                ack_drv <= 1'b0;
            end else if (busy_q) begin
                if (scl_rise && !ack_drv) begin
                    shreg   <= {shreg[DATA_W-2:0], sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall) begin
                    if (ack_drv) begin
                        ack_drv <= 1'b0;
                        bit_cnt <= '0;
                    end else if (bit_cnt == 4'd8) begin
                        case (phase)
                            PH_ADDR: begin
                                if (shreg == {DEV_ADDR, 1'b0}) begin
                                    ack_drv <= 1'b1;
                                    phase   <= PH_SUB;
                                end else begin
                                    busy_q  <= 1'b0;
                                end
                            end
                            PH_SUB: begin
                                sub_q   <= shreg;
                                ack_drv <= 1'b1;
                                phase   <= PH_DATA;
                            end
                            default: begin
                                wr_en   <= 1'b1;
                                wr_addr <= sub_q;
                                wr_data <= shreg;
                                ack_drv <= 1'b1;
                                phase   <= PH_SUB;
                            end
                        endcase
                    end
                end
            end
        end
    end

    assign idle = ~busy_q;
endmodule

// File: rtl/pcfg_regfile.sv
// Register file of REG_CNT byte-wide slots. Slots with a zero mask are
// constant zero; the others reset to their power-on value and keep only
// their masked bits on a write strobe. An index outside the slots matches
// nothing.
module pcfg_regfile
    import pcfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [REG_CNT-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < REG_CNT; i++) begin : g_slot
        localparam logic [DATA_W-1:0] MASK = field_mask(i);
        localparam logic [DATA_W-1:0] INIT = por_value(i);
        if (MASK != '0) begin : g_reg
            // Hold one configuration value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= INIT;
                else if (wr_en && wr_addr == DATA_W'(i))
                    q[i] <= wr_data & MASK;
            end
        end else begin : g_none
            assign q[i] = '0;
        end
    end
endmodule

// File: rtl/preamp_cfg_slave.sv
// Top of the preamplifier configuration bank. It filters both bus lines,
// runs the write-only protocol engine and maps register slots onto
// parallel output buses. Assumes an external open-drain bus where
// sda_pull_o high pulls SDA low.
module preamp_cfg_slave
    import pcfg_pkg::*;
#(
    parameter int FILT_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] contrast_o,
    output logic [7:0] brightness_o,
    output logic [7:0] drive0_o,
    output logic [7:0] drive1_o,
    output logic [7:0] drive2_o,
    output logic [3:0] osd_level_o,
    output logic [7:0] clamp_cfg_o,
    output logic [7:0] misc_cfg_o,
    output logic [7:0] cutoff0_o,
    output logic [7:0] cutoff1_o,
    output logic [7:0] cutoff2_o,
    output logic [3:0] bandwidth_o
);
    logic [1:0]                     line_raw, line_clean;
    logic                           scl_f, sda_f;
    logic                           wr_en, bus_idle;
    logic [DATA_W-1:0]              wr_addr, wr_data;
    logic [REG_CNT-1:0][DATA_W-1:0] regs;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        pcfg_deglitch #(.STABLE_CYC(FILT_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (line_raw[g]),
            .clean (line_clean[g])
        );
    end

    assign scl_f = line_clean[1];
    assign sda_f = line_clean[0];

    pcfg_wr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_f),
        .sda     (sda_f),
        .ack_drv (sda_pull_o),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .idle    (bus_idle)
    );

    pcfg_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .q       (regs)
    );

    assign contrast_o   = regs[1];
    assign brightness_o = regs[2];
    assign drive0_o     = regs[3];
    assign drive1_o     = regs[4];
    assign drive2_o     = regs[5];
    assign osd_level_o  = regs[7][3:0];
    assign clamp_cfg_o  = regs[8];
    assign misc_cfg_o   = regs[9];
    assign cutoff0_o    = regs[10];
    assign cutoff1_o    = regs[11];
    assign cutoff2_o    = regs[12];
    assign bandwidth_o  = regs[13][3:0];

    wire unused_slots = ^{regs[0], regs[6], regs[7][7:4], regs[13][7:4],
                          regs[14], regs[15]};
endmodule

// File: rtl/pcfg_checker.sv
// Property checker for preamp_cfg_slave, attached by bind. It observes the
// filtered clock, the acknowledge pull, the write strobe, the idle flag
// and two register outputs.
module pcfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_pull_o,
    input logic       wr_en,
    input logic       bus_idle,
    input logic [7:0] contrast_o,
    input logic [3:0] osd_level_o
);
    AST_POR_LOAD: assert property (@(posedge clk)
        !rst_n |=> (contrast_o == 8'hB4 && osd_level_o == 4'h9 && !sda_pull_o)); // R1

    AST_ACK_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_f); // R2

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !sda_pull_o); // R3

    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_pull_o); // R4

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R5

    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(contrast_o) |-> $past(wr_en)); // R7
endmodule

bind preamp_cfg_slave pcfg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_f       (scl_f),
    .sda_pull_o  (sda_pull_o),
    .wr_en       (wr_en),
    .bus_idle    (bus_idle),
    .contrast_o  (contrast_o),
    .osd_level_o (osd_level_o)
);

// File: tb/preamp_cfg_slave_tb.sv
module preamp_cfg_slave_tb_top;
    localparam int H = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_o;
    logic [7:0] contrast_o, brightness_o, drive0_o, drive1_o, drive2_o;
    logic [7:0] clamp_cfg_o, misc_cfg_o, cutoff0_o, cutoff1_o, cutoff2_o;
    logic [3:0] osd_level_o, bandwidth_o;
    logic sda_line;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;
    logic [7:0] exp_q [16];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_o;

    preamp_cfg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull_o), .contrast_o(contrast_o),
        .brightness_o(brightness_o), .drive0_o(drive0_o),
        .drive1_o(drive1_o), .drive2_o(drive2_o),
        .osd_level_o(osd_level_o), .clamp_cfg_o(clamp_cfg_o),
        .misc_cfg_o(misc_cfg_o), .cutoff0_o(cutoff0_o),
        .cutoff1_o(cutoff1_o), .cutoff2_o(cutoff2_o),
        .bandwidth_o(bandwidth_o)
    );

    function automatic logic [7:0] bench_por(input int i);
        case (i)
            1, 2, 3, 4, 5, 10, 11, 12: return 8'hB4;
            7: return 8'h09;
            8: return 8'h04;
            9: return 8'h1C;
            13: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] bench_mask(input int i);
        if (i == 7 || i == 13) return 8'h0F;
        if (i >= 1 && i <= 13 && i != 6) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] port_val(input int i);
        case (i)
            1: return contrast_o;
            2: return brightness_o;
            3: return drive0_o;
            4: return drive1_o;
            5: return drive2_o;
            7: return {4'h0, osd_level_o};
            8: return clamp_cfg_o;
            9: return misc_cfg_o;
            10: return cutoff0_o;
            11: return cutoff1_o;
            12: return cutoff2_o;
            13: return {4'h0, bandwidth_o};
            default: return 8'h00;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, expv);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 1; i <= 13; i++) begin
            if (i != 6) check(req, port_val(i), exp_q[i]);
        end
    endtask

    task automatic bus_start();
        tick(H / 2); sda_m = 1'b1; tick(H / 2); scl_m = 1'b1;
        tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(H / 2); sda_m = 1'b0; tick(H / 2); scl_m = 1'b1;
        tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b, input logic glitch);
        tick(H / 2); sda_m = b; tick(H / 2); scl_m = 1'b1;
        if (glitch) begin
            tick(H / 2); scl_m = 1'b0; tick(1); scl_m = 1'b1; tick(H / 2 - 1);
        end else begin
            tick(H);
        end
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int glitch_at, output logic ack);
        for (int k = 7; k >= 0; k--) send_bit(b[k], (k == glitch_at));
        tick(H / 2); sda_m = 1'b1; tick(H / 2); scl_m = 1'b1;
        tick(H / 2); ack = sda_pull_o; tick(H / 2); scl_m = 1'b0;
    endtask

    // Write one index/data pair inside an already started transaction.
    task automatic put_pair(input logic [7:0] idx, input logic [7:0] dat, input string req);
        logic a;
        send_byte(idx, -1, a); check(req, {7'd0, a}, 8'd1);
        send_byte(dat, -1, a); check(req, {7'd0, a}, 8'd1);
        if (bench_mask(int'(idx)) != 8'h00 && idx < 8'd16)
            exp_q[idx[3:0]] = dat & bench_mask(int'(idx));
    endtask

    task automatic write_one(input logic [7:0] idx, input logic [7:0] dat, input string req);
        logic a;
        bus_start();
        send_byte(8'hDC, -1, a); check("R2", {7'd0, a}, 8'd1);
        put_pair(idx, dat, req);
        bus_stop();
        tick(20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < 16; i++) exp_q[i] = bench_por(i);
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1: power-on values and released acknowledge pull
        check_all("R1");
        check("R1", {7'd0, sda_pull_o}, 8'd0);

        // R4, R5, R6, R7: every index 0x00..0x0F plus out-of-range, as pairs in one transaction
        bus_start();
        send_byte(8'hDC, -1, a); check("R2", {7'd0, a}, 8'd1);
        for (int i = 0; i < 16; i++)
            put_pair(8'(i), 8'((i * 37 + 11) & 8'hFF), (i == 0 || i == 6 || i > 13) ? "R7" : "R5");
        put_pair(8'h20, 8'h00, "R7");
        put_pair(8'hFF, 8'h00, "R7");
        bus_stop();
        tick(20);
        check_all("R5");

        // R4, R6: inverted pattern, one write per transaction, checked each time
        for (int i = 0; i < 16; i++) begin
            write_one(8'(i), 8'(~((i * 37 + 11) & 8'hFF)), "R4");
            check_all((i == 7 || i == 13) ? "R6" : "R4");
        end

        // R3: foreign address, then the read request; later bytes ignored
        bus_start();
        send_byte(8'hA0, -1, a); check("R3", {7'd0, a}, 8'd0);
        send_byte(8'h01, -1, a); check("R3", {7'd0, a}, 8'd0);
        send_byte(8'h00, -1, a); check("R3", {7'd0, a}, 8'd0);
        bus_stop();
        bus_start();
        send_byte(8'hDD, -1, a); check("R3", {7'd0, a}, 8'd0);
        send_byte(8'h02, -1, a); check("R3", {7'd0, a}, 8'd0);
        send_byte(8'h11, -1, a); check("R3", {7'd0, a}, 8'd0);
        bus_stop();
        tick(20);
        check_all("R3");

        // R8: STOP in the middle of a data byte aborts it
        bus_start();
        send_byte(8'hDC, -1, a);
        send_byte(8'h01, -1, a);
        for (int k = 0; k < 5; k++) send_bit(k[0], 1'b0);
        bus_stop();
        tick(20);
        check("R8", contrast_o, exp_q[1]);

        // R8: repeated START in the middle of a data byte, then a fresh write
        bus_start();
        send_byte(8'hDC, -1, a);
        send_byte(8'h02, -1, a);
        for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b0);
        bus_start();
        send_byte(8'hDC, -1, a); check("R8", {7'd0, a}, 8'd1);
        put_pair(8'h03, 8'h55, "R8");
        bus_stop();
        tick(20);
        check("R8", brightness_o, exp_q[2]);
        check("R8", drive0_o, 8'h55);

        // R9: short SCL glitch inside a data bit is not counted as an edge
        bus_start();
        send_byte(8'hDC, -1, a);
        send_byte(8'h01, -1, a);
        send_byte(8'h3C, 3, a); check("R9", {7'd0, a}, 8'd1);
        bus_stop();
        tick(20);
        exp_q[1] = 8'h3C;
        check("R9", contrast_o, 8'h3C);
        check_all("R9");

        // R1: reset in the middle of use restores power-on values
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        for (int i = 0; i < 16; i++) exp_q[i] = bench_por(i);
        check_all("R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule